// File: doc/BRIEF.md
# Vector Compare and Masked Arithmetic Unit

This block holds a small file of vector registers and runs two kinds of element-wise operation over them, one element per clock. A compare takes two vector registers, or one vector register and a broadcast scalar, and tests each element pair for equality, inequality or signed greater-than. The result goes into a per-element mask register, not into a data register. A later add or subtract can then run under that mask. An element whose mask bit is clear keeps its old destination value, so a compare followed by arithmetic acts as a vectorised conditional.

Every operation runs over the first `vlen` elements. The unit takes the length with the operation. It fills the register file through an element write port and reads it back through a registered read port. Operands are 64-bit two's complement integers. Each operation ends with a one-cycle `done` pulse.

Top module: `vcm_unit`

## Requirements
- R1: After reset `mask_out` is all ones, and `busy` and `done` are 0.
- R2: Compare operations use op code 0 for equal and op code 1 for not-equal. Each sets mask bit i to the result for element i.
- R3: Op code 2 sets mask bit i when element i of source A is greater than the B operand, with both read as signed two's complement.
- R4: With `use_scalar` = 1, the `scalar` input replaces the B operand for every element of a compare or arithmetic operation.
- R5: A compare clears every mask bit at index `vlen` or above.
- R6: Op code 3 (A + B) and op code 4 (A − B) with `mask_en` = 1 write destination element i only when mask bit i is 1. Other elements keep their old value.
- R7: With `mask_en` = 0, arithmetic writes every element below `vlen`. No operation changes a destination element at index `vlen` or above.
- R8: Add and subtract wrap modulo 2^64.
- R9: `done` is a single-cycle pulse. It rises `vlen`+2 rising edges after the edge that takes `start`, or 1 edge after for `vlen` = 0. A `vlen` above 64 acts as 64.
- R10: `start` is ignored while `busy` is 1 or when `op` is 5, 6 or 7. A load on `ld_en` is ignored while `busy` is 1.
- R11: `rd_data` shows element `rd_idx` of register `rd_reg` one clock edge after the address is applied.
- R12: Add and subtract leave `mask_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | 2 | Register written by a load |
| ld_idx | input | 6 | Element written by a load |
| ld_data | input | 64 | Load data |
| rd_reg | input | 2 | Read-back register select |
| rd_idx | input | 6 | Read-back element select |
| rd_data | output | 64 | Registered read-back data |
| start | input | 1 | Begin an operation |
| op | input | 3 | 0 eq, 1 ne, 2 signed gt, 3 add, 4 sub |
| use_scalar | input | 1 | Take B from `scalar` |
| src_a | input | 2 | Source A register |
| src_b | input | 2 | Source B register |
| dst | input | 2 | Destination register for arithmetic |
| scalar | input | 64 | Broadcast B operand |
| mask_en | input | 1 | Arithmetic honours the mask |
| vlen | input | 7 | Number of active elements |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation-complete pulse |
| mask_out | output | 64 | Current mask register |

## Verification
The hardest condition to reach from the ports is a request that arrives while an operation is still running. Both a second `start` and an element load land between the read and write stages of the pipeline. The bench launches an addition over a length of 20 and pulses a compare and a load a few cycles later. It then checks that neither the mask nor the loaded element changed. Zero and over-range lengths are driven directly, so both the one-edge completion and the clamp to 64 are observed.

// File: rtl/vcm_pkg.sv
package vcm_pkg;
  typedef enum logic [2:0] {
    OP_EQ  = 3'd0,
    OP_NE  = 3'd1,
    OP_GT  = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4
  } vop_e;

  function automatic logic op_valid(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic op_is_cmp(input logic [2:0] code);
    return code <= 3'd2;
  endfunction
endpackage

// File: rtl/vcm_regfile.sv
module vcm_regfile #(
  parameter int DW    = 64,
  parameter int DEPTH = 256,
  parameter int NRP   = 3,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr [NRP],
  output logic [DW-1:0] rdata [NRP]
);
  // One replica per read port, each a simple dual-port RAM with a registered read.
  for (genvar g = 0; g < NRP; g++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rd_q <= mem[raddr[g]];
    end
    assign rdata[g] = rd_q;
  end
endmodule

// File: rtl/vcm_lane.sv
module vcm_lane #(
  parameter int DW = 64
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          cmp_bit,
  output logic [DW-1:0] res
);
  import vcm_pkg::*;

  always_comb begin
    cmp_bit = 1'b0;
    res     = a + b;
    case (vop_e'(op))
      OP_EQ:  cmp_bit = (a == b);
      OP_NE:  cmp_bit = (a != b);
      OP_GT:  cmp_bit = ($signed(a) > $signed(b));
      OP_SUB: res     = a - b;
      default: res    = a + b;
    endcase
  end
endmodule

// File: rtl/vcm_seq.sv
module vcm_seq #(
  parameter int MVL = 64,
  parameter int RW  = 2,
  parameter int DW  = 64,
  parameter int LW  = $clog2(MVL + 1),
  parameter int IW  = $clog2(MVL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [2:0]    op_in,
  input  logic          use_scalar_in,
  input  logic [RW-1:0] src_a_in,
  input  logic [RW-1:0] src_b_in,
  input  logic [RW-1:0] dst_in,
  input  logic [DW-1:0] scalar_in,
  input  logic          mask_en_in,
  input  logic [LW-1:0] vlen_in,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] issue_idx,
  output logic          s1_v,
  output logic [IW-1:0] s1_idx,
  output logic [2:0]    op_q,
  output logic          use_scalar_q,
  output logic [RW-1:0] src_a_q,
  output logic [RW-1:0] src_b_q,
  output logic [RW-1:0] dst_q,
  output logic [DW-1:0] scalar_q,
  output logic          mask_en_q,
  output logic [LW-1:0] vlen_q
);
  import vcm_pkg::*;

  localparam logic [LW-1:0] MAXLEN = LW'(MVL);

  logic [LW-1:0] cnt;
  logic [LW-1:0] vlen_eff;
  logic          issue;

  assign accept    = start && !busy && op_valid(op_in);
  assign vlen_eff  = (vlen_in > MAXLEN) ? MAXLEN : vlen_in;
  assign issue     = busy && (cnt < vlen_q);
  assign issue_idx = cnt[IW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      done         <= 1'b0;
      cnt          <= '0;
      s1_v         <= 1'b0;
      s1_idx       <= '0;
      op_q         <= 3'd0;
      use_scalar_q <= 1'b0;
      src_a_q      <= '0;
      src_b_q      <= '0;
      dst_q        <= '0;
      scalar_q     <= '0;
      mask_en_q    <= 1'b0;
      vlen_q       <= '0;
    end else begin
      done <= 1'b0;
      s1_v <= issue;
      if (issue) begin
        s1_idx <= cnt[IW-1:0];
        cnt    <= cnt + 1'b1;
      end
      if (accept) begin
        busy         <= 1'b1;
        cnt          <= '0;
        op_q         <= op_in;
        use_scalar_q <= use_scalar_in;
        src_a_q      <= src_a_in;
        src_b_q      <= src_b_in;
        dst_q        <= dst_in;
        scalar_q     <= scalar_in;
        mask_en_q    <= mask_en_in;
        vlen_q       <= vlen_eff;
      end else if (busy && !issue && !s1_v) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9: the element counter never runs past the active length
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= vlen_q) && (vlen_q <= MAXLEN));
  // R10: a start while busy leaves the latched operation alone
  a_r10_start_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(op_q) && $stable(vlen_q) && $stable(dst_q)));
  // R9: a stage-1 element only exists during an operation
  a_r9_stage_in_op: assert property (@(posedge clk) disable iff (rst)
    s1_v |-> busy);
endmodule

// File: rtl/vcm_unit.sv
module vcm_unit #(
  parameter int NREG = 4,
  parameter int MVL  = 64,
  parameter int DW   = 64,
  localparam int RW    = $clog2(NREG),
  localparam int IW    = $clog2(MVL),
  localparam int LW    = $clog2(MVL + 1),
  localparam int AW    = RW + IW,
  localparam int DEPTH = NREG * MVL
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [RW-1:0] ld_reg,
  input  logic [IW-1:0] ld_idx,
  input  logic [DW-1:0] ld_data,
  input  logic [RW-1:0] rd_reg,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic          use_scalar,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [RW-1:0] dst,
  input  logic [DW-1:0] scalar,
  input  logic          mask_en,
  input  logic [LW-1:0] vlen,
  output logic          busy,
  output logic          done,
  output logic [MVL-1:0] mask_out
);
  import vcm_pkg::*;

  logic          accept;
  logic [IW-1:0] issue_idx;
  logic          s1_v;
  logic [IW-1:0] s1_idx;
  logic [2:0]    op_q;
  logic          use_scalar_q;
  logic [RW-1:0] src_a_q, src_b_q, dst_q;
  logic [DW-1:0] scalar_q;
  logic          mask_en_q;
  logic [LW-1:0] vlen_q;

  vcm_seq #(.MVL(MVL), .RW(RW), .DW(DW), .LW(LW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .op_in(op),
    .use_scalar_in(use_scalar), .src_a_in(src_a), .src_b_in(src_b),
    .dst_in(dst), .scalar_in(scalar), .mask_en_in(mask_en), .vlen_in(vlen),
    .accept(accept), .busy(busy), .done(done), .issue_idx(issue_idx),
    .s1_v(s1_v), .s1_idx(s1_idx), .op_q(op_q), .use_scalar_q(use_scalar_q),
    .src_a_q(src_a_q), .src_b_q(src_b_q), .dst_q(dst_q), .scalar_q(scalar_q),
    .mask_en_q(mask_en_q), .vlen_q(vlen_q)
  );

  logic [AW-1:0] raddr [3];
  logic [DW-1:0] rdata [3];
  logic          rf_we;
  logic [AW-1:0] rf_waddr;
  logic [DW-1:0] rf_wdata;

  assign raddr[0] = {src_a_q, issue_idx};
  assign raddr[1] = {src_b_q, issue_idx};
  assign raddr[2] = {rd_reg, rd_idx};
  assign rd_data  = rdata[2];

  vcm_regfile #(.DW(DW), .DEPTH(DEPTH), .NRP(3), .AW(AW)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .raddr(raddr), .rdata(rdata)
  );

  logic [DW-1:0] opnd_b;
  logic          cmp_bit;
  logic [DW-1:0] alu_res;

  assign opnd_b = use_scalar_q ? scalar_q : rdata[1];

  vcm_lane #(.DW(DW)) u_lane (
    .op(op_q), .a(rdata[0]), .b(opnd_b), .cmp_bit(cmp_bit), .res(alu_res)
  );

  logic          run_cmp;
  logic          exec_we;
  logic [MVL-1:0] mask_q;

  assign run_cmp = op_is_cmp(op_q);
  assign exec_we = s1_v && !run_cmp && (!mask_en_q || mask_q[s1_idx]);

  // Execution writes only happen while busy, so the load path is used only when idle.
  always_comb begin
    if (exec_we) begin
      rf_we    = 1'b1;
      rf_waddr = {dst_q, s1_idx};
      rf_wdata = alu_res;
    end else begin
      rf_we    = ld_en && !busy;
      rf_waddr = {ld_reg, ld_idx};
      rf_wdata = ld_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (accept && op_is_cmp(op)) begin
      mask_q <= '0;
    end else if (s1_v && run_cmp) begin
      mask_q[s1_idx] <= cmp_bit;
    end
  end

  assign mask_out = mask_q;

  logic [MVL-1:0] tail_m;
  always_comb begin
    for (int i = 0; i < MVL; i++) tail_m[i] = (i >= int'(vlen_q));
  end

  // R1: the first cycle out of reset shows an all-ones mask
  a_r1_reset_mask: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask_q) && !busy && !done);
  // R5: a finished compare leaves no mask bit set at or beyond the length
  a_r5_tail_clear: assert property (@(posedge clk) disable iff (rst)
    (done && run_cmp) |-> ((mask_q & tail_m) == '0));
  // R6: a masked-off element is never written by arithmetic
  a_r6_masked_off: assert property (@(posedge clk) disable iff (rst)
    (s1_v && !run_cmp && mask_en_q && !mask_q[s1_idx]) |-> !(rf_we && rf_waddr == {dst_q, s1_idx}));
  // R12: arithmetic leaves the mask untouched
  a_r12_mask_kept: assert property (@(posedge clk) disable iff (rst)
    (busy && !run_cmp && !accept) |=> $stable(mask_q));
  // R10: loads are not applied while an operation runs
  a_r10_no_load_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && rf_we) |-> exec_we);
endmodule

// File: tb/vcm_unit_bench.sv
module vcm_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        ld_en;
  logic [1:0]  ld_reg;
  logic [5:0]  ld_idx;
  logic [63:0] ld_data;
  logic [1:0]  rd_reg;
  logic [5:0]  rd_idx;
  logic [63:0] rd_data;
  logic        start;
  logic [2:0]  op;
  logic        use_scalar;
  logic [1:0]  src_a, src_b, dst;
  logic [63:0] scalar;
  logic        mask_en;
  logic [6:0]  vlen;
  logic        busy, done;
  logic [63:0] mask_out;

  vcm_unit u_vcm_unit (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx),
    .ld_data(ld_data), .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
    .start(start), .op(op), .use_scalar(use_scalar), .src_a(src_a),
    .src_b(src_b), .dst(dst), .scalar(scalar), .mask_en(mask_en),
    .vlen(vlen), .busy(busy), .done(done), .mask_out(mask_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] mrf [4][64];
  logic [63:0] mmask;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ld(input int r, input int i, input logic [63:0] d);
    ld_en = 1'b1; ld_reg = 2'(r); ld_idx = 6'(i); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
    mrf[r][i] = d;
  endtask

  task automatic rd(input int r, input int i, output logic [63:0] d);
    rd_reg = 2'(r); rd_idx = 6'(i);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic check_reg(input int r, input string tag);
    logic [63:0] d;
    for (int i = 0; i < 64; i++) begin
      rd(r, i, d);
      chk($sformatf("%s reg%0d[%0d]", tag, r, i), d, mrf[r][i]);
    end
  endtask

  function automatic logic [63:0] mix(input int seed, input int i);
    return (64'h9E3779B97F4A7C15 * 64'(i + 1 + seed * 131)) ^ (64'(seed) << 40);
  endfunction

  task automatic model_op(input logic [2:0] o, input logic us, input int a, input int b,
                          input int d, input logic [63:0] sc, input logic me, input int vl);
    int ve;
    logic [63:0] bv;
    ve = (vl > 64) ? 64 : vl;
    for (int i = 0; i < 64; i++) begin
      bv = us ? sc : mrf[b][i];
      if (o <= 3'd2) begin
        if (i >= ve) mmask[i] = 1'b0;
        else if (o == 3'd0) mmask[i] = (mrf[a][i] == bv);
        else if (o == 3'd1) mmask[i] = (mrf[a][i] != bv);
        else mmask[i] = ($signed(mrf[a][i]) > $signed(bv));
      end else if (i < ve && (!me || mmask[i])) begin
        mrf[d][i] = (o == 3'd3) ? mrf[a][i] + bv : mrf[a][i] - bv;
      end
    end
  endtask

  task automatic drive_start(input logic [2:0] o, input logic us, input int a, input int b,
                             input int d, input logic [63:0] sc, input logic me, input int vl);
    op = o; use_scalar = us; src_a = 2'(a); src_b = 2'(b); dst = 2'(d);
    scalar = sc; mask_en = me; vlen = 7'(vl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (done !== 1'b1 && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic exec(input logic [2:0] o, input logic us, input int a, input int b,
                      input int d, input logic [63:0] sc, input logic me, input int vl,
                      input string tag);
    int n, ve;
    ve = (vl > 64) ? 64 : vl;
    model_op(o, us, a, b, d, sc, me, vl);
    drive_start(o, us, a, b, d, sc, me, vl);
    wait_done(n);
    chk({tag, " R9 latency"}, 64'(n), (ve == 0) ? 64'd1 : 64'(ve + 2));
    @(negedge clk);
    chk({tag, " R9 done single"}, 64'(done), 64'd0);
    chk({tag, " mask"}, mask_out, mmask);
  endtask

  task automatic t_reset;
    chk("R1 mask after reset", mask_out, {64{1'b1}});
    chk("R1 busy after reset", 64'(busy), 64'd0);
    chk("R1 done after reset", 64'(done), 64'd0);
    mmask = {64{1'b1}};
  endtask

  task automatic t_load;
    logic [63:0] d;
    for (int i = 0; i < 64; i++) begin
      ld(0, i, mix(1, i));
      case (i % 3)
        0: ld(1, i, mix(1, i));
        1: ld(1, i, mix(1, i) + 64'd5);
        default: ld(1, i, mix(1, i) - 64'd5);
      endcase
      ld(2, i, mix(7, i));
      ld(3, i, mix(9, i));
    end
    ld(3, 63, 64'h0123_4567_89AB_CDEF);
    rd(3, 63, d);
    chk("R11 read after one edge", d, 64'h0123_4567_89AB_CDEF);
  endtask

  task automatic t_cmp_eq;
    exec(3'd0, 1'b0, 0, 1, 0, 64'd0, 1'b0, 64, "R2 eq vv");
  endtask

  task automatic t_cmp_ne_scalar;
    exec(3'd1, 1'b1, 0, 0, 0, mrf[0][7], 1'b0, 40, "R4 R5 ne scalar len40");
    chk("R5 tail bits clear", mask_out & ~((64'd1 << 40) - 1), 64'd0);
    chk("R4 matched element bit", 64'(mask_out[7]), 64'd0);
  endtask

  task automatic t_cmp_gt_signed;
    ld(2, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    ld(2, 1, 64'h0000_0000_0000_0001);
    ld(2, 2, 64'h8000_0000_0000_0000);
    ld(2, 3, 64'h0000_0000_0000_0000);
    exec(3'd2, 1'b1, 2, 0, 0, 64'd0, 1'b0, 64, "R3 gt signed vs zero");
    chk("R3 minus one not greater", 64'(mask_out[0]), 64'd0);
    chk("R3 plus one greater", 64'(mask_out[1]), 64'd1);
    exec(3'd2, 1'b0, 0, 1, 0, 64'd0, 1'b0, 64, "R3 gt vv");
  endtask

  task automatic t_add_masked;
    logic [63:0] m;
    m = mmask;
    exec(3'd3, 1'b0, 0, 1, 2, 64'd0, 1'b1, 50, "R6 R8 add masked");
    chk("R12 mask kept by add", mask_out, m);
    check_reg(2, "R6 R7 R8 add masked");
  endtask

  task automatic t_sub_unmasked;
    exec(3'd4, 1'b1, 0, 0, 3, 64'hFFFF_0000_1234_5678, 1'b0, 17, "R7 sub scalar unmasked");
    check_reg(3, "R7 R8 sub unmasked");
  endtask

  task automatic t_len_edges;
    exec(3'd0, 1'b0, 0, 0, 0, 64'd0, 1'b0, 0, "R9 R5 zero length");
    chk("R5 zero length mask", mask_out, 64'd0);
    exec(3'd3, 1'b0, 0, 1, 1, 64'd0, 1'b1, 64, "R6 all masked off");
    check_reg(1, "R6 all masked off");
    exec(3'd0, 1'b0, 0, 0, 0, 64'd0, 1'b0, 100, "R9 clamp 100 to 64");
    chk("R9 clamp full mask", mask_out, {64{1'b1}});
  endtask

  task automatic t_busy_ignore;
    int n;
    logic [63:0] m;
    m = mmask;
    model_op(3'd3, 1'b0, 0, 1, 2, 64'd0, 1'b0, 20);
    drive_start(3'd3, 1'b0, 0, 1, 2, 64'd0, 1'b0, 20);
    @(negedge clk);
    @(negedge clk);
    op = 3'd0; vlen = 7'd64; start = 1'b1;
    ld_en = 1'b1; ld_reg = 2'd3; ld_idx = 6'd5; ld_data = 64'hDEAD_BEEF_0000_0001;
    @(negedge clk);
    start = 1'b0; ld_en = 1'b0;
    wait_done(n);
    chk("R10 start while busy no relaunch", 64'(n), 64'd19);
    @(negedge clk);
    chk("R10 mask after ignored compare", mask_out, m);
    check_reg(3, "R10 load while busy ignored");
    check_reg(2, "R10 add result");
    drive_start(3'd5, 1'b0, 0, 1, 2, 64'd0, 1'b0, 10);
    chk("R10 bad op no busy", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R10 bad op no done", 64'(done), 64'd0);
    chk("R10 bad op mask", mask_out, m);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; ld_en = 1'b0; ld_reg = '0; ld_idx = '0; ld_data = '0;
    rd_reg = '0; rd_idx = '0; start = 1'b0; op = '0; use_scalar = 1'b0;
    src_a = '0; src_b = '0; dst = '0; scalar = '0; mask_en = 1'b0; vlen = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_load();
    t_cmp_eq();
    t_cmp_ne_scalar();
    t_cmp_gt_signed();
    t_add_masked();
    t_sub_unmasked();
    t_len_edges();
    t_busy_ignore();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule